// File: doc/BRIEF.md
# Configurable Pin Event Detector

This block watches a single asynchronous digital input and records selected events on it in a sticky status flag. A 4-bit trigger code chooses what counts as an event and what the flag raises. Edge codes react to a rising, falling or any transition of the synchronized input. Level codes react while the input is low or high. The code also decides whether a set flag drives an interrupt line or a DMA request line.

The flag is cleared in one of two ways. Software can write 1 to the flag bit of the control word. When a DMA code is active, the DMA engine can pulse its completion strobe instead. A lock bit freezes the lower half of the control word, including the lock bit itself, until the next reset. While locked, the trigger code and the flag can still be written.

The flag is a two-state machine with the states FLAG_CLEAR and FLAG_PENDING:
- It moves from FLAG_CLEAR to FLAG_PENDING on a detected edge.
- It also moves from FLAG_CLEAR to FLAG_PENDING on an active level, provided no clear arrives in the same cycle.
- It moves from FLAG_PENDING back to FLAG_CLEAR on a software or DMA clear, unless an edge is detected in that same cycle.
- In every other case it stays where it is.

Control word layout (32 bits, read back on `reg_rdata_o`):

| Bits | Meaning |
|------|---------|
| 24 | Flag. Writing 1 clears it; writing 0 has no effect. |
| 19:16 | Trigger code. |
| 15 | Lock bit. |
| 14:0 | Pad field, driven out on `pad_ctl_o`. Only the bits set in `PAD_MASK` are stored. |
| 31:25, 23:20 | Reserved. |

Top module: `pin_event_unit`

## Requirements
- R1: After reset the control word reads 0, and `irq_o` and `dma_req_o` are low.
- R2: The edge codes are as follows. Codes 1 and 9 detect a rising edge. Codes 2 and 10 detect a falling edge. Codes 3 and 11 detect any edge. Code 8 sets the flag while the input is 0, and code 12 sets it while the input is 1.
- R3: Codes 1 to 3 drive `dma_req_o` from the flag, and codes 8 to 12 drive `irq_o` from the flag. The two outputs are never high together.
- R4: Code 0 and the reserved codes 4 to 7 and 13 to 15 never set the flag, and they keep both requests low.
- R5: Writing 1 to bit 24 clears the flag. Writing 0 to bit 24 leaves the flag unchanged.
- R6: A `dma_done_i` pulse clears the flag only while a DMA code (1 to 3) is selected. Under any other code the pulse has no effect.
- R7: In a level code, a clear applied while the input is still active drops the flag for exactly one cycle, and the flag sets again on the next cycle.
- R8: When an edge is detected in the same cycle as a clear, the flag stays set.
- R9: While bit 15 is 1, writes to bits 15:0 are ignored until reset. Bits 19:16 and the flag stay writable.
- R10: Reserved bits, and pad bits not set in `PAD_MASK`, read back as 0 whatever is written to them.
- R11: A change on `pin_i` shows in the flag after three clock edges: two synchronizer stages, then the flag register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Asynchronous pin level |
| reg_wr_i | input | 1 | Control word write strobe |
| reg_wdata_i | input | 32 | Control word write data |
| reg_rdata_o | output | 32 | Control word readback |
| pad_ctl_o | output | 15 | Stored pad field (bits 14:0) |
| irq_o | output | 1 | Interrupt request |
| dma_req_o | output | 1 | DMA request |
| dma_done_i | input | 1 | DMA transfer completion strobe |

## Verification
The bench builds the block with the default two synchronizer stages and `PAD_MASK` = 15'h0F07. This makes the three-cycle event latency exact, and it makes the masked pad bits visible in readback. With these values, all sixteen trigger codes can be swept against both a rising and a falling stimulus. Expected flag, interrupt and DMA values are derived arithmetically from the code. Directed sequences then cover the same-cycle clear collisions, the level re-assertion, the lock freeze and the reserved-bit masking.

// File: rtl/pin_evt_pkg.sv
package pin_evt_pkg;

    localparam int FLAG_BIT = 24;
    localparam int CODE_LSB = 16;
    localparam int CODE_W   = 4;
    localparam int LOCK_BIT = 15;
    localparam int PAD_W    = 15;

    typedef enum logic [2:0] {
        TRIG_NONE,
        TRIG_RISE,
        TRIG_FALL,
        TRIG_ANY,
        TRIG_LOW,
        TRIG_HIGH
    } trig_t;

    typedef enum logic [1:0] {
        REQ_NONE,
        REQ_DMA,
        REQ_IRQ
    } req_t;

    typedef struct packed {
        trig_t trig;
        req_t  req;
    } mode_t;

    function automatic mode_t decode_code(input logic [CODE_W-1:0] code);
        mode_t m;
        case (code)
            4'd1:    m = '{TRIG_RISE, REQ_DMA};
            4'd2:    m = '{TRIG_FALL, REQ_DMA};
            4'd3:    m = '{TRIG_ANY,  REQ_DMA};
            4'd8:    m = '{TRIG_LOW,  REQ_IRQ};
            4'd9:    m = '{TRIG_RISE, REQ_IRQ};
            4'd10:   m = '{TRIG_FALL, REQ_IRQ};
            4'd11:   m = '{TRIG_ANY,  REQ_IRQ};
            4'd12:   m = '{TRIG_HIGH, REQ_IRQ};
            default: m = '{TRIG_NONE, REQ_NONE};
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    output logic level_o,
    output logic prev_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) chain_q[0] <= 1'b0;
                    else         chain_q[0] <= pin_i;
                end
            end else begin : g_next
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) chain_q[i] <= 1'b0;
                    else         chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= chain_q[STAGES-1];
    end

    assign level_o = chain_q[STAGES-1];
    assign prev_o  = prev_q;
endmodule

// File: rtl/trig_detect.sv
module trig_detect
    import pin_evt_pkg::*;
(
    input  logic  level_i,
    input  logic  prev_i,
    input  mode_t mode_i,
    output logic  edge_hit_o,
    output logic  level_hit_o
);
    logic rise;
    logic fall;

    assign rise = level_i & ~prev_i;
    assign fall = ~level_i & prev_i;

    always_comb begin
        edge_hit_o  = 1'b0;
        level_hit_o = 1'b0;
        unique case (mode_i.trig)
            TRIG_RISE: edge_hit_o  = rise;
            TRIG_FALL: edge_hit_o  = fall;
            TRIG_ANY:  edge_hit_o  = rise | fall;
            TRIG_LOW:  level_hit_o = ~level_i;
            TRIG_HIGH: level_hit_o = level_i;
            default:   ;
        endcase
    end
endmodule

// File: rtl/flag_fsm.sv
module flag_fsm (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic edge_hit_i,
    input  logic level_hit_i,
    input  logic clr_i,
    output logic flag_o
);
    typedef enum logic {
        FLAG_CLEAR,
        FLAG_PENDING
    } flag_state_t;

    flag_state_t state_q;
    flag_state_t state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= FLAG_CLEAR;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR: begin
                if (edge_hit_i || (level_hit_i && !clr_i)) state_d = FLAG_PENDING;
            end
            FLAG_PENDING: begin
                if (clr_i && !edge_hit_i) state_d = FLAG_CLEAR;
            end
            default: state_d = FLAG_CLEAR;
        endcase
    end

    always_comb begin
        flag_o = (state_q == FLAG_PENDING);
    end
endmodule

// File: rtl/pin_event_unit.sv
module pin_event_unit
    import pin_evt_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [PAD_W-1:0]  PAD_MASK    = 15'h0F07
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        pin_i,
    input  logic        reg_wr_i,
    input  logic [31:0] reg_wdata_i,
    output logic [31:0] reg_rdata_o,
    output logic [14:0] pad_ctl_o,
    output logic        irq_o,
    output logic        dma_req_o,
    input  logic        dma_done_i
);
    localparam int CODE_MSB = CODE_LSB + CODE_W - 1;

    logic [CODE_W-1:0] code_q;
    logic              lock_q;
    logic [PAD_W-1:0]  pad_q;
    mode_t             mode;
    logic              level;
    logic              prev;
    logic              edge_hit;
    logic              level_hit;
    logic              sw_clr;
    logic              dma_clr;
    logic              flag;
    logic              unused_wdata;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            code_q <= '0;
            lock_q <= 1'b0;
            pad_q  <= '0;
        end else if (reg_wr_i) begin
            code_q <= reg_wdata_i[CODE_MSB:CODE_LSB];
            if (!lock_q) begin
                lock_q <= reg_wdata_i[LOCK_BIT];
                pad_q  <= reg_wdata_i[PAD_W-1:0] & PAD_MASK;
            end
        end
    end

    assign mode = decode_code(code_q);

    pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .pin_i   (pin_i),
        .level_o (level),
        .prev_o  (prev)
    );

    trig_detect u_detect (
        .level_i     (level),
        .prev_i      (prev),
        .mode_i      (mode),
        .edge_hit_o  (edge_hit),
        .level_hit_o (level_hit)
    );

    assign sw_clr  = reg_wr_i & reg_wdata_i[FLAG_BIT];
    assign dma_clr = dma_done_i & (mode.req == REQ_DMA);

    flag_fsm u_flag (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .edge_hit_i  (edge_hit),
        .level_hit_i (level_hit),
        .clr_i       (sw_clr | dma_clr),
        .flag_o      (flag)
    );

    assign irq_o     = flag & (mode.req == REQ_IRQ);
    assign dma_req_o = flag & (mode.req == REQ_DMA);
    assign pad_ctl_o = pad_q;

    always_comb begin
        reg_rdata_o                    = '0;
        reg_rdata_o[FLAG_BIT]          = flag;
        reg_rdata_o[CODE_MSB:CODE_LSB] = code_q;
        reg_rdata_o[LOCK_BIT]          = lock_q;
        reg_rdata_o[PAD_W-1:0]         = pad_q;
    end

    assign unused_wdata = ^{reg_wdata_i[31:25], reg_wdata_i[23:20]};
endmodule

// File: rtl/pin_event_unit_chk.sv
module pin_event_unit_chk #(
    parameter logic [14:0] PAD_MASK = 15'h0F07
) (
    input logic        clk_i,
    input logic        rst_ni,
    input logic [31:0] reg_rdata_o,
    input logic        irq_o,
    input logic        dma_req_o,
    input logic        dma_done_i,
    input logic        edge_hit
);
    logic       flag;
    logic       code_off;
    logic [3:0] code;

    assign flag     = reg_rdata_o[24];
    assign code     = reg_rdata_o[19:16];
    assign code_off = !((code >= 4'd1 && code <= 4'd3) || (code >= 4'd8 && code <= 4'd12));

    // R3
    irq_dma_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(irq_o && dma_req_o));

    // R4
    off_no_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!flag && code_off) |=> !flag);

    // R6
    dma_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dma_req_o && dma_done_i && !edge_hit) |=> !flag);

    // R8
    edge_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        edge_hit |=> flag);

    // R9
    lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reg_rdata_o[15] |=> (reg_rdata_o[15] && $stable(reg_rdata_o[14:0])));

    // R10
    rsv_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_rdata_o[31:25] == 7'd0) && (reg_rdata_o[23:20] == 4'd0)
        && ((reg_rdata_o[14:0] & ~PAD_MASK) == 15'd0));
endmodule

bind pin_event_unit pin_event_unit_chk #(.PAD_MASK(PAD_MASK)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o),
    .dma_req_o   (dma_req_o),
    .dma_done_i  (dma_done_i),
    .edge_hit    (edge_hit)
);

// File: tb/pin_event_unit_bench.sv
`timescale 1ns/1ps
module pin_event_unit_bench;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        pin_i = 1'b0;
    logic        reg_wr_i = 1'b0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic [14:0] pad_ctl_o;
    logic        irq_o;
    logic        dma_req_o;
    logic        dma_done_i = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk_i = ~clk_i;

    pin_event_unit u_pin_event_unit (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .pin_i       (pin_i),
        .reg_wr_i    (reg_wr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .pad_ctl_o   (pad_ctl_o),
        .irq_o       (irq_o),
        .dma_req_o   (dma_req_o),
        .dma_done_i  (dma_done_i)
    );

    function automatic bit rise_c(int c); return c == 1 || c == 3 || c == 9 || c == 11; endfunction
    function automatic bit fall_c(int c); return c == 2 || c == 3 || c == 10 || c == 11; endfunction
    function automatic bit irq_c(int c);  return c >= 8 && c <= 12; endfunction
    function automatic bit dma_c(int c);  return c >= 1 && c <= 3; endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk_i);
    endtask

    task automatic wr(logic [31:0] d);
        reg_wr_i    = 1'b1;
        reg_wdata_i = d;
        @(negedge clk_i);
        reg_wr_i    = 1'b0;
        reg_wdata_i = '0;
    endtask

    task automatic do_reset();
        rst_ni = 1'b0;
        pin_i  = 1'b0;
        cyc(3);
        rst_ni = 1'b1;
        cyc(3);
    endtask

    function automatic logic flag();
        return reg_rdata_o[24];
    endfunction

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk_i);
        do_reset();

        // R1: reset state
        chk("R1 rdata", reg_rdata_o, 32'h0);
        chk("R1 irq/dma", {irq_o, dma_req_o}, 2'b00);

        // R2 R3 R4: sweep all codes with rising and falling stimulus
        for (int c = 0; c < 16; c++) begin
            for (int p = 0; p < 2; p++) begin
                logic st;
                logic en;
                bit pre_e;
                bit post_e;
                st = (p == 1);
                en = ~st;
                pin_i = st;
                wr(32'h0100_0000);
                cyc(5);
                wr((32'(c) << 16) | 32'h0100_0000);
                cyc(3);
                pre_e = (c == 8 && st == 0) || (c == 12 && st == 1);
                chk(c == 0 || !(rise_c(c) || fall_c(c) || c == 8 || c == 12) ? "R4 pre" : "R2 pre",
                    flag(), pre_e);
                pin_i = en;
                cyc(3);
                post_e = pre_e || (p == 0 ? rise_c(c) : fall_c(c))
                         || (c == 8 && en == 0) || (c == 12 && en == 1);
                chk(post_e ? "R2 flag" : "R4 flag", flag(), post_e);
                chk("R3 irq", irq_o, post_e && irq_c(c));
                chk("R3 dma", dma_req_o, post_e && dma_c(c));
            end
        end

        // R11: latency of a rising edge under code 9
        pin_i = 1'b0;
        wr(32'h0009_0000 | 32'h0100_0000);
        cyc(4);
        pin_i = 1'b1;
        cyc(2);
        chk("R11 not yet", flag(), 1'b0);
        cyc(1);
        chk("R11 set", flag(), 1'b1);

        // R5: writing 0 leaves flag, writing 1 clears
        wr(32'h0009_0000);
        chk("R5 w0", flag(), 1'b1);
        wr(32'h0109_0000);
        chk("R5 w1", flag(), 1'b0);

        // R6: dma_done ignored in interrupt mode
        pin_i = 1'b0;
        cyc(4);
        pin_i = 1'b1;
        cyc(3);
        dma_done_i = 1'b1;
        cyc(1);
        dma_done_i = 1'b0;
        chk("R6 irq mode keeps", flag(), 1'b1);
        // R6: dma_done clears in DMA mode (code 1)
        pin_i = 1'b0;
        wr(32'h0101_0000);
        cyc(4);
        pin_i = 1'b1;
        cyc(3);
        chk("R6 dma req", dma_req_o, 1'b1);
        dma_done_i = 1'b1;
        cyc(1);
        dma_done_i = 1'b0;
        chk("R6 dma clears", flag(), 1'b0);
        chk("R6 dma req low", dma_req_o, 1'b0);

        // R7: level re-assert with code 12
        wr(32'h010C_0000);
        cyc(2);
        chk("R7 level set", flag(), 1'b1);
        wr(32'h010C_0000);
        chk("R7 drop", flag(), 1'b0);
        cyc(1);
        chk("R7 reassert", flag(), 1'b1);

        // R8: clear in the edge cycle loses
        pin_i = 1'b0;
        wr(32'h0109_0000);
        cyc(4);
        chk("R8 idle", flag(), 1'b0);
        pin_i = 1'b1;
        cyc(2);
        wr(32'h0109_0000);
        chk("R8 set wins", flag(), 1'b1);
        wr(32'h0109_0000);
        chk("R8 later clear", flag(), 1'b0);

        // R9: lock freeze
        do_reset();
        wr(32'h0000_8305);
        chk("R9 locked", reg_rdata_o, 32'h0000_8305);
        chk("R9 pad", pad_ctl_o, 15'h0305);
        wr(32'h0009_0000);
        chk("R9 code writable", reg_rdata_o, 32'h0009_8305);
        chk("R9 pad frozen", pad_ctl_o, 15'h0305);
        pin_i = 1'b1;
        cyc(3);
        chk("R9 flag sets", flag(), 1'b1);
        wr(32'h0109_0000);
        chk("R9 flag clearable", flag(), 1'b0);

        // R10: reserved bits
        do_reset();
        wr(32'hFFFF_FFFF);
        chk("R10 readback", reg_rdata_o, 32'h000F_8F07);

        done = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule